// File: doc/BRIEF.md
# Field Synchronization Segment Generator

This block emits the 832-symbol synchronization segment that opens every field of an 8-level vestigial-sideband broadcast frame. Each symbol is a bipolar level of plus or minus five. One symbol is produced per cycle of a symbol enable. A start pulse, taken only while the block is idle, latches the field parity, a 24-bit mode word and a 92-bit reserved word. The segment then runs to its end without further control. A frame holds two fields of 313 segments, so a sync segment is requested twice per frame.

The segment is assembled from fixed sections. A four-symbol header comes first, then a 511-symbol pseudo-noise run from a nine-stage shift register and three copies of a 63-symbol run from a six-stage register. The middle of those three copies is inverted on alternate fields. After them come the mode and reserved words and a 12-symbol tail. The tail repeats the final twelve symbols of the preceding segment. Those symbols enter serially on `prevBit` while the generator is idle and are kept in a 12-entry history. The block is intended as the reference pattern source for a correlator bench.

Top module: `fsync_gen`

## Requirements
- R1: During reset and after it, with no accepted start, `symValid` and `symLast` stay 0 and `symLevel` is 0. A reset in the middle of a segment aborts it, and no further symbols follow until a new start.
- R2: A `startPulse` seen while idle latches `fieldOdd`, `modeWord`, `resvWord` and the tail history. Later changes on those inputs do not affect the segment. A `startPulse` seen while a segment is running is ignored.
- R3: Each clock with `symEn` high during a segment produces exactly one symbol, with `symValid` high on the following cycle. A segment holds exactly 832 symbols. `symLast` is high with the 832nd only, and the cycle after it carries no symbol.
- R4: A bit of 0 is sent as level -5 (4'b1011) and a bit of 1 as level +5 (4'b0101) in every section. `symLevel` is 0 whenever `symValid` is low.
- R5: Symbols 0 to 3 are -5, +5, +5, -5.
- R6: Symbols 4 to 514 are the long sequence. Its first nine bits are 0,1,0,0,0,0,0,0,0. Every later bit is a[n+9] = a[n+7] ^ a[n+6] ^ a[n+4] ^ a[n+3] ^ a[n+1] ^ a[n].
- R7: Symbols 515 to 703 are three back-to-back copies of the short sequence. Each copy restarts from the bits 1,0,0,1,1,1 and continues with a[n+6] = a[n+1] ^ a[n], for 63 bits.
- R8: When the latched `fieldOdd` is 1, every bit of the middle copy (symbols 578 to 640) is inverted. The first and third copies are never inverted.
- R9: Symbols 704 to 727 carry `modeWord`, bit 23 first.
- R10: Symbols 728 to 819 carry `resvWord`, bit 91 first.
- R11: Symbols 820 to 831 repeat the last twelve `prevBit` values sampled while idle, oldest first. A sample is taken on each clock where `symEn` is high and `startPulse` is low.
- R12: A clock with `symEn` low during a segment produces no symbol and does not advance the segment. The sequence resumes unchanged on the next enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symEn | input | 1 | Symbol enable; one symbol per high cycle |
| startPulse | input | 1 | Request a segment; honoured only while idle |
| fieldOdd | input | 1 | Field parity; 1 inverts the middle short copy |
| modeWord | input | 24 | Mode bits, sent MSB first |
| resvWord | input | 92 | Reserved bits, sent MSB first |
| prevBit | input | 1 | Serial history of the previous segment's final symbols |
| symLevel | output | 4 | Signed symbol level, +5 or -5 |
| symValid | output | 1 | Symbol strobe |
| symLast | output | 1 | Marks symbol 831 |

## Verification
On every cycle the assertions check that valid levels are only plus or minus five and that idle cycles carry zero. They also check that every symbol follows an enabled clock and that the header pattern holds. A port-side count confirms that the last flag falls on the 832nd symbol and is followed by a gap. The pseudo-noise contents, the middle-copy inversion, the word ordering and the tail history are shown only by the bench's scenarios. Those scenarios compare each symbol with a model built from the recurrences. The same holds for the rejection of a start mid-segment and for recovery from a reset mid-segment.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int SYNC_LEN     = 4;
  localparam int LONG_LEN     = 511;
  localparam int SHORT_LEN    = 63;
  localparam int SHORT_COPIES = 3;
  localparam int MODE_LEN     = 24;
  localparam int RESV_LEN     = 92;
  localparam int TAIL_LEN     = 12;

  localparam int LONG_BASE  = SYNC_LEN;
  localparam int SHORT_BASE = LONG_BASE + LONG_LEN;
  localparam int MODE_BASE  = SHORT_BASE + SHORT_LEN * SHORT_COPIES;
  localparam int RESV_BASE  = MODE_BASE + MODE_LEN;
  localparam int TAIL_BASE  = RESV_BASE + RESV_LEN;
  localparam int SEG_LEN    = TAIL_BASE + TAIL_LEN;

  localparam int IDX_W  = $clog2(SEG_LEN);
  localparam int OFS_W  = $clog2(LONG_LEN);
  localparam int COPY_W = $clog2(SHORT_COPIES);
  localparam int MID_COPY = SHORT_COPIES / 2;

  // long register: 9 stages, x^9+x^7+x^6+x^4+x^3+x+1, low-order coefficient mask
  localparam int LONG_W = 9;
  localparam logic [LONG_W-1:0] LONG_POLY = 9'b011011011;
  localparam logic [LONG_W-1:0] LONG_SEED = 9'b010000000;
  // short register: 6 stages, x^6+x+1
  localparam int SHORT_W = 6;
  localparam logic [SHORT_W-1:0] SHORT_POLY = 6'b000011;
  localparam logic [SHORT_W-1:0] SHORT_SEED = 6'b100111;

  typedef enum logic [2:0] {
    SEC_HDR, SEC_LONG, SEC_SHORT, SEC_MODE, SEC_RESV, SEC_TAIL
  } sec_e;

  typedef struct packed {
    logic              capture;
    logic              emit;
    logic              histShift;
    sec_e              sec;
    logic [COPY_W-1:0] copy;
    logic [OFS_W-1:0]  ofs;
    logic              shortWrap;
    logic              lastSym;
  } strobe_t;
endpackage

// File: rtl/fsync_lfsr.sv
module fsync_lfsr #(
  parameter int          W    = 9,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic adv,
  output logic outBit
);
  // state[W-1] holds a[n]; state[W-1-k] holds a[n+k], so coefficient k taps bit W-1-k
  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[W-1-k] = v[k];
    return r;
  endfunction

  localparam logic [W-1:0] TAPS = mirror(POLY);

  logic [W-1:0] state;
  logic         fb;

  assign fb     = ^(state & TAPS);
  assign outBit = state[W-1];

  always_ff @(posedge clk) begin
    if (!rstN)     state <= SEED;
    else if (load) state <= SEED;
    else if (adv)  state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
  import fsync_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    symEn,
  input  logic    startPulse,
  output strobe_t stb
);
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             emit;
  sec_e             sec;
  logic [COPY_W-1:0] copy;
  int               rel;
  int               ofsInt;

  assign accept = startPulse && !busy;
  assign emit   = symEn && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (emit) begin
      if (idx == IDX_W'(SEG_LEN - 1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    rel    = int'(idx);
    sec    = SEC_HDR;
    copy   = '0;
    ofsInt = rel;
    if (rel >= TAIL_BASE) begin
      sec    = SEC_TAIL;
      ofsInt = rel - TAIL_BASE;
    end else if (rel >= RESV_BASE) begin
      sec    = SEC_RESV;
      ofsInt = rel - RESV_BASE;
    end else if (rel >= MODE_BASE) begin
      sec    = SEC_MODE;
      ofsInt = rel - MODE_BASE;
    end else if (rel >= SHORT_BASE) begin
      sec    = SEC_SHORT;
      ofsInt = rel - SHORT_BASE;
      for (int c = 1; c < SHORT_COPIES; c++) begin
        if (rel - SHORT_BASE >= c * SHORT_LEN) begin
          copy   = COPY_W'(c);
          ofsInt = rel - SHORT_BASE - c * SHORT_LEN;
        end
      end
    end else if (rel >= LONG_BASE) begin
      sec    = SEC_LONG;
      ofsInt = rel - LONG_BASE;
    end
  end

  always_comb begin
    stb.capture   = accept;
    stb.emit      = emit;
    stb.histShift = symEn && !busy && !startPulse;
    stb.sec       = sec;
    stb.copy      = copy;
    stb.ofs       = OFS_W'(ofsInt);
    stb.shortWrap = emit && (sec == SEC_SHORT) && (ofsInt == SHORT_LEN - 1);
    stb.lastSym   = (idx == IDX_W'(SEG_LEN - 1));
  end
endmodule

// File: rtl/fsync_dp.sv
module fsync_dp
  import fsync_pkg::*;
#(
  parameter int LEVEL_W   = 4,
  parameter int LEVEL_MAG = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic                      fieldOdd,
  input  logic [MODE_LEN-1:0]       modeWord,
  input  logic [RESV_LEN-1:0]       resvWord,
  input  logic                      prevBit,
  output logic signed [LEVEL_W-1:0] symLevel,
  output logic                      symValid,
  output logic                      symLast
);
  localparam int HDR_IW  = $clog2(SYNC_LEN);
  localparam int MODE_IW = $clog2(MODE_LEN);
  localparam int RESV_IW = $clog2(RESV_LEN);
  localparam int TAIL_IW = $clog2(TAIL_LEN);
  localparam logic [SYNC_LEN-1:0] HDR_BITS = 4'b0110;
  localparam logic signed [LEVEL_W-1:0] LVL_HI = LEVEL_W'(LEVEL_MAG);
  localparam logic signed [LEVEL_W-1:0] LVL_LO = -LEVEL_W'(LEVEL_MAG);

  logic                invMid;
  logic [MODE_LEN-1:0] modeReg;
  logic [RESV_LEN-1:0] resvReg;
  logic [TAIL_LEN-1:0] hist;
  logic [TAIL_LEN-1:0] histSnap;
  logic longBit, shortBit, curBit;
  logic [OFS_W-1:0] modeIdx, resvIdx, tailIdx;

  fsync_lfsr #(.W(LONG_W), .POLY(LONG_POLY), .SEED(LONG_SEED)) u_long (
    .clk(clk), .rstN(rstN),
    .load(stb.capture),
    .adv(stb.emit && stb.sec == SEC_LONG),
    .outBit(longBit)
  );

  fsync_lfsr #(.W(SHORT_W), .POLY(SHORT_POLY), .SEED(SHORT_SEED)) u_short (
    .clk(clk), .rstN(rstN),
    .load(stb.capture || stb.shortWrap),
    .adv(stb.emit && stb.sec == SEC_SHORT && !stb.shortWrap),
    .outBit(shortBit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invMid   <= 1'b0;
      modeReg  <= '0;
      resvReg  <= '0;
      hist     <= '0;
      histSnap <= '0;
    end else begin
      if (stb.capture) begin
        invMid   <= fieldOdd;
        modeReg  <= modeWord;
        resvReg  <= resvWord;
        histSnap <= hist;
      end
      if (stb.histShift) hist <= {hist[TAIL_LEN-2:0], prevBit};
    end
  end

  assign modeIdx = OFS_W'(MODE_LEN - 1) - stb.ofs;
  assign resvIdx = OFS_W'(RESV_LEN - 1) - stb.ofs;
  assign tailIdx = OFS_W'(TAIL_LEN - 1) - stb.ofs;

  always_comb begin
    unique case (stb.sec)
      SEC_HDR:   curBit = HDR_BITS[stb.ofs[HDR_IW-1:0]];
      SEC_LONG:  curBit = longBit;
      SEC_SHORT: curBit = shortBit ^ (invMid && stb.copy == COPY_W'(MID_COPY));
      SEC_MODE:  curBit = modeReg[modeIdx[MODE_IW-1:0]];
      SEC_RESV:  curBit = resvReg[resvIdx[RESV_IW-1:0]];
      SEC_TAIL:  curBit = histSnap[tailIdx[TAIL_IW-1:0]];
      default:   curBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symValid <= 1'b0;
      symLast  <= 1'b0;
      symLevel <= '0;
    end else begin
      symValid <= stb.emit;
      symLast  <= stb.emit && stb.lastSym;
      symLevel <= stb.emit ? (curBit ? LVL_HI : LVL_LO) : '0;
    end
  end
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsync_pkg::*;
#(
  parameter int LEVEL_W   = 4,
  parameter int LEVEL_MAG = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      symEn,
  input  logic                      startPulse,
  input  logic                      fieldOdd,
  input  logic [MODE_LEN-1:0]       modeWord,
  input  logic [RESV_LEN-1:0]       resvWord,
  input  logic                      prevBit,
  output logic signed [LEVEL_W-1:0] symLevel,
  output logic                      symValid,
  output logic                      symLast
);
  strobe_t stb;

  fsync_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .symEn(symEn), .startPulse(startPulse), .stb(stb)
  );

  fsync_dp #(.LEVEL_W(LEVEL_W), .LEVEL_MAG(LEVEL_MAG)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fieldOdd(fieldOdd), .modeWord(modeWord), .resvWord(resvWord), .prevBit(prevBit),
    .symLevel(symLevel), .symValid(symValid), .symLast(symLast)
  );
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk
  import fsync_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              symEn,
  input logic signed [3:0] symLevel,
  input logic              symValid,
  input logic              symLast
);
  logic [IDX_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN)         seen <= '0;
    else if (symLast)  seen <= '0;
    else if (symValid) seen <= seen + 1'b1;
  end

  a_r4_level_legal: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> (symLevel == 4'sd5 || symLevel == -4'sd5));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |-> symLevel == 4'sd0);

  a_r3_last_position: assert property (@(posedge clk) disable iff (!rstN)
    symLast |-> (symValid && seen == IDX_W'(SEG_LEN - 1)));

  a_r3_gap_after_last: assert property (@(posedge clk) disable iff (!rstN)
    symLast |=> !symValid);

  a_r12_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> $past(symEn));

  a_r5_header: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && seen < IDX_W'(SYNC_LEN)) |->
      symLevel == ((seen == 1 || seen == 2) ? 4'sd5 : -4'sd5));
endmodule

bind fsync_gen fsync_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .symEn(symEn),
  .symLevel(symLevel), .symValid(symValid), .symLast(symLast)
);

// File: tb/fsync_gen_tb.sv
module fsync_gen_tb;
  import fsync_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symEn = 1'b0;
  logic startPulse = 1'b0;
  logic fieldOdd = 1'b0;
  logic prevBit = 1'b0;
  logic [MODE_LEN-1:0] modeWord = '0;
  logic [RESV_LEN-1:0] resvWord = '0;
  logic signed [3:0] symLevel;
  logic symValid, symLast;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit longA [LONG_LEN];
  bit shortA[SHORT_LEN];

  localparam int NSCN = 4;
  localparam logic [NSCN-1:0] PARS = 4'b0110;  // bit i = scenario i
  localparam logic [MODE_LEN-1:0] MODES [NSCN] =
    '{24'h5A0FF3, 24'hFFFFFF, 24'h000000, 24'h81C3E7};
  localparam logic [RESV_LEN-1:0] RESVS [NSCN] =
    '{92'h0, 92'hFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
      92'h123_4567_89AB_CDEF_0123_4567, 92'hA5A_5A5A_5A5A_5A5A_5A5A_5A5A};
  localparam logic [TAIL_LEN-1:0] HISTS [NSCN] = '{12'hF0A, 12'h001, 12'hFFF, 12'h5C3};
  localparam int GAPS    [NSCN] = '{0, 0, 3, 2};
  localparam int IGNORES [NSCN] = '{-1, -1, 300, 50};

  always #5 clk = ~clk;

  fsync_gen u_dut (
    .clk(clk), .rstN(rstN), .symEn(symEn), .startPulse(startPulse),
    .fieldOdd(fieldOdd), .modeWord(modeWord), .resvWord(resvWord), .prevBit(prevBit),
    .symLevel(symLevel), .symValid(symValid), .symLast(symLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string tagFor(input int i);
    if (i < LONG_BASE)  return "R5";
    if (i < SHORT_BASE) return "R6";
    if (i < MODE_BASE)  return "R7/R8";
    if (i < RESV_BASE)  return "R9";
    if (i < TAIL_BASE)  return "R10";
    return "R11";
  endfunction

  function automatic bit expBit(input int i, input bit par, input logic [MODE_LEN-1:0] m,
                                input logic [RESV_LEN-1:0] r, input logic [TAIL_LEN-1:0] h);
    int o;
    bit b;
    if (i < LONG_BASE)  return (i == 1 || i == 2);
    if (i < SHORT_BASE) return longA[i - LONG_BASE];
    if (i < MODE_BASE) begin
      o = i - SHORT_BASE;
      b = shortA[o % SHORT_LEN];
      if ((o / SHORT_LEN) == 1 && par) b = ~b;
      return b;
    end
    if (i < RESV_BASE)  return m[MODE_LEN - 1 - (i - MODE_BASE)];
    if (i < TAIL_BASE)  return r[RESV_LEN - 1 - (i - RESV_BASE)];
    return h[TAIL_LEN - 1 - (i - TAIL_BASE)];
  endfunction

  // R1: outputs must be idle and zero
  task automatic checkIdle(input string what);
    check(!symValid && !symLast && symLevel == 0, what, int'(symValid) + int'(symLast) + int'(symLevel), 0);
  endtask

  task automatic runSeg(input int s);
    int outCnt = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit par = PARS[s];
    logic [TAIL_LEN-1:0] h = HISTS[s];
    // R11: sixteen samples, only the last twelve count
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      symEn = 1'b1;
      prevBit = (k < 4) ? k[0] : h[15 - k];
    end
    @(negedge clk);
    symEn = 1'b0;
    startPulse = 1'b1;
    fieldOdd = par;
    modeWord = MODES[s];
    resvWord = RESVS[s];
    prevBit = 1'b0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      if (symValid) begin
        // R4 level mapping checked through the exact level
        check(symLevel == (expBit(outCnt, par, MODES[s], RESVS[s], h) ? 4'sd5 : -4'sd5),
              tagFor(outCnt), int'(symLevel),
              expBit(outCnt, par, MODES[s], RESVS[s], h) ? 5 : -5);
        check(symLast == (outCnt == SEG_LEN - 1), "R3 last flag", int'(symLast),
              int'(outCnt == SEG_LEN - 1));
        outCnt++;
        if (symLast) done = 1'b1;
      end else begin
        check(!symLast, "R3 last without valid", int'(symLast), 0);
      end
      // R2: inputs change after capture, and one start lands mid-segment
      startPulse = (cyc == IGNORES[s]);
      fieldOdd = ~par;
      modeWord = ~MODES[s];
      resvWord = ~RESVS[s];
      prevBit = ~prevBit;
      // R12: enable gaps
      symEn = (GAPS[s] == 0) ? 1'b1 : ((cyc % GAPS[s]) != 0);
      cyc++;
    end
    check(outCnt == SEG_LEN, "R3 symbol count", outCnt, SEG_LEN);
    @(negedge clk);
    check(!symValid, "R3 gap after last", int'(symValid), 0);
    symEn = 1'b0;
    startPulse = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < LONG_W; k++) longA[k] = LONG_SEED[LONG_W - 1 - k];
    for (int n = 0; n + LONG_W < LONG_LEN; n++)
      longA[n+9] = longA[n+7] ^ longA[n+6] ^ longA[n+4] ^ longA[n+3] ^ longA[n+1] ^ longA[n];
    for (int k = 0; k < SHORT_W; k++) shortA[k] = SHORT_SEED[SHORT_W - 1 - k];
    for (int n = 0; n + SHORT_W < SHORT_LEN; n++)
      shortA[n+6] = shortA[n+1] ^ shortA[n];

    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    symEn = 1'b1;
    repeat (5) @(negedge clk);
    checkIdle("R1 idle after reset");

    for (int s = 0; s < NSCN; s++) runSeg(s);

    // R1: reset in the middle of a segment
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    symEn = 1'b1;
    repeat (100) @(negedge clk);
    check(symValid, "R1 segment running", int'(symValid), 1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkIdle("R1 mid-segment reset");
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    checkIdle("R1 no resume after reset");
    symEn = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule